// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral that sits on a byte-wide register bus. It holds a free-running 32-bit count of seconds that advances by one on each pulse of a one-second tick input, but only while counting is enabled. Software sets the count by filling a set of staging bytes. The write to the least significant staging byte moves the whole staged value into the counter in a single step. Software reads the live count back one byte per access.

A four-byte alarm value is compared against the count on every tick. The alarm status latches when the alarm is enabled and a tick brings the count to the alarm value. The status drives a level interrupt and stays set until software clears it through a second control register.

All multi-byte values are unsigned and little-endian: byte 0 is the least significant. The bus has no wide atomic access, so a read of the count can tear across a carry. Software detects this by reading byte 0 a second time and comparing the two values.

Top module: `secrtc_top`

## Requirements
- R1: After reset, the control registers, staging bytes, alarm bytes and count are all zero, and `alarm_irq` is low.
- R2: One byte moves per bus access. The offsets are: 0x0 control, 0x1 alarm control, 0x2–0x5 staging bytes 0–3, 0x6–0x9 live count bytes 0–3, and 0xA–0xD alarm bytes 0–3, with byte 0 the least significant. A read places its byte on `bus_rdata` in the cycle after the access, and `bus_rdata` holds its value until the next read. Offsets 0xE and 0xF read as 0x00, and writes to them are ignored.
- R3: A write to offset 0x2 loads the count in one step with {staged byte 3, staged byte 2, staged byte 1, written byte}. Writes to 0x3–0x5 only change the staging bytes. Every staging byte reads back at its own offset.
- R4: The count advances by one on a cycle with `tick` high only when control bit 7 is 1. When a load and a tick fall in the same cycle, the loaded value wins.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000 on the next tick.
- R6: Bytes 0x6–0x9 show the live count. When a carry occurs between byte reads, a second read of byte 0 returns a smaller value than the first, and a full re-read then returns the new count.
- R7: When control bit 1 is 1 and a tick advances the count to the alarm value, the alarm status sets and `alarm_irq` goes high. The status stays set after the alarm enable is cleared. A load that makes the count equal to the alarm value does not set the status.
- R8: Writing a byte with bit 0 set to offset 0x1 clears the alarm status and `alarm_irq`. If a set and a clear happen in the same cycle, the set wins. Bit 0 of offset 0x1 reads as the alarm status.
- R9: The undefined bits of both control registers (control bits 6..2 and 0, alarm-control bits 7..1) read back the last value written to them and have no effect on behaviour.
- R10: Writes to the live count bytes (0x6–0x9) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The load path is swept with two dozen scattered 32-bit values, each read back byte by byte. Each value is then advanced by a varying number of ticks, which separates the byte-lane order from the increment carries. The all-ones value confirms the wrap. Ticks with counting disabled, and a tick in the same cycle as a load, show which source controls the counter. A value of 0x1FF with a tick placed between two byte reads produces a torn read, and the bench applies the byte 0 re-read rule to detect it. The alarm is checked on the tick before the match and on the matching tick, after a load that makes the count equal to the alarm, and with a set and a clear in the same cycle. Together these cases separate the level compare from the event latch and confirm the set-over-clear priority.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  // Offset map; software decodes these, so they are fixed.
  localparam int OFS_CTRL = 0;
  localparam int OFS_ACTL = 1;
  localparam int OFS_STG  = 2;
  // Control bit positions
  localparam int BIT_RUN  = 7;
  localparam int BIT_AEN  = 1;
  localparam int BIT_ACLR = 0;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_ACTL, SEL_STAGE, SEL_LIVE, SEL_ALARM, SEL_NONE
  } sel_e;
endpackage

// File: rtl/secrtc_regs.sv
module secrtc_regs
  import secrtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4,
  parameter int ADDR_W = 4,
  localparam int CNT_W = DATA_W * NBYTES,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              alarm_status,
  output logic              run_en,
  output logic              alarm_en,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  alarm_val,
  output logic              clear_stb
);
  localparam int LIVE_LO  = OFS_STG + NBYTES;
  localparam int ALARM_LO = OFS_STG + 2 * NBYTES;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] actl_q;
  logic [DATA_W-1:0] stage_q [NBYTES];
  logic [DATA_W-1:0] alarm_q [NBYTES];
  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic              wr;
  logic [DATA_W-1:0] rd_mux;

  // Address decode
  always_comb begin
    int a;
    a   = int'(bus_addr);
    sel = SEL_NONE;
    idx = '0;
    if (a == OFS_CTRL) sel = SEL_CTRL;
    else if (a == OFS_ACTL) sel = SEL_ACTL;
    else if (a >= OFS_STG && a < LIVE_LO) begin
      sel = SEL_STAGE; idx = IDX_W'(a - OFS_STG);
    end else if (a >= LIVE_LO && a < ALARM_LO) begin
      sel = SEL_LIVE; idx = IDX_W'(a - LIVE_LO);
    end else if (a >= ALARM_LO && a < ALARM_LO + NBYTES) begin
      sel = SEL_ALARM; idx = IDX_W'(a - ALARM_LO);
    end
  end

  assign wr        = bus_valid & bus_write;
  assign load_stb  = wr && (sel == SEL_STAGE) && (idx == '0);
  assign clear_stb = wr && (sel == SEL_ACTL) && bus_wdata[BIT_ACLR];
  assign run_en    = ctrl_q[BIT_RUN];
  assign alarm_en  = ctrl_q[BIT_AEN];

  // Flattened views of staged load value and alarm value
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign load_val[DATA_W-1:0] = bus_wdata;
    end else begin : g_high
      assign load_val[g*DATA_W +: DATA_W] = stage_q[g];
    end
    assign alarm_val[g*DATA_W +: DATA_W] = alarm_q[g];
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      actl_q <= '0;
      for (int i = 0; i < NBYTES; i++) begin
        stage_q[i] <= '0;
        alarm_q[i] <= '0;
      end
    end else if (wr) begin
      case (sel)
        SEL_CTRL:  ctrl_q <= bus_wdata;
        SEL_ACTL:  actl_q <= bus_wdata;
        SEL_STAGE: stage_q[idx] <= bus_wdata;
        SEL_ALARM: alarm_q[idx] <= bus_wdata;
        default:   ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    case (sel)
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_ACTL:  rd_mux = {actl_q[DATA_W-1:1], alarm_status};
      SEL_STAGE: rd_mux = stage_q[idx];
      SEL_LIVE:  rd_mux = count[idx*DATA_W +: DATA_W];
      SEL_ALARM: rd_mux = alarm_q[idx];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
  end

  // R2: read data holds between reads
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
  // R9: a control write lands exactly as written
  p_ctrl_written_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_CTRL) |=> ctrl_q == $past(bus_wdata));
endmodule

// File: rtl/secrtc_counter.sv
module secrtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_en,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             advance,
  output logic [CNT_W-1:0] count_inc
);
  assign advance   = tick & run_en & ~load_stb;
  assign count_inc = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load_stb) count <= load_val;
    else if (advance)  count <= count_inc;
  end

  // R3: load commits the whole staged value
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> count == $past(load_val));
  // R4: no movement when stopped and not loading
  p_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !load_stb) |=> $stable(count));
  // R5: a step is modulo 2**CNT_W
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && run_en && !load_stb) |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/secrtc_alarm.sv
module secrtc_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alarm_en,
  input  logic             advance,
  input  logic [CNT_W-1:0] count_inc,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             clear_stb,
  output logic             status
);
  logic hit;
  assign hit = alarm_en & advance & (count_inc == alarm_val);

  always_ff @(posedge clk) begin
    if (rst)            status <= 1'b0;
    else if (hit)       status <= 1'b1;
    else if (clear_stb) status <= 1'b0;
  end

  // R7: status is sticky until a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status && !clear_stb) |=> status);
  // R8: a clear without a coinciding advance drops the status
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clear_stb && !advance) |=> !status);
  // R7: without an advance the status never rises
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (!status && !advance) |=> !status);
endmodule

// File: rtl/secrtc_top.sv
module secrtc_top #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  localparam int CNT_W = DATA_W * NBYTES;

  logic [CNT_W-1:0] count, count_inc, load_val, alarm_val;
  logic run_en, alarm_en, load_stb, clear_stb, advance, status;

  secrtc_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .alarm_status(status),
    .run_en(run_en), .alarm_en(alarm_en),
    .load_stb(load_stb), .load_val(load_val),
    .alarm_val(alarm_val), .clear_stb(clear_stb)
  );

  secrtc_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run_en(run_en),
    .load_stb(load_stb), .load_val(load_val),
    .count(count), .advance(advance), .count_inc(count_inc)
  );

  secrtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst(rst), .alarm_en(alarm_en), .advance(advance),
    .count_inc(count_inc), .alarm_val(alarm_val),
    .clear_stb(clear_stb), .status(status)
  );

  assign alarm_irq = status;

  // R1: interrupt low in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !alarm_irq);
endmodule

// File: tb/secrtc_top_test.sv
module secrtc_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ctrl_shadow = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  secrtc_top uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    ctrl_shadow = v;
    bus_wr(4'h0, v);
  endtask

  task automatic read_count(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      bus_rd(4'(6 + i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  // Legal load: stop, zero byte 0, upper bytes, real byte 0, restore
  task automatic load_count(input logic [31:0] v);
    logic [7:0] keep;
    keep = ctrl_shadow;
    bus_wr(4'h0, keep & 8'h7F);
    bus_wr(4'h2, 8'h00);
    bus_wr(4'h3, v[15:8]);
    bus_wr(4'h4, v[23:16]);
    bus_wr(4'h5, v[31:24]);
    bus_wr(4'h2, v[7:0]);
    bus_wr(4'h0, keep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp;
    logic [7:0] b, b0a, b0b;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    bus_rd(4'h0, b); chk("R1 ctrl", {24'h0, b}, 32'h0);
    read_count(v);   chk("R1 count", v, 32'h0);
    bus_rd(4'hA, b); chk("R1 alarm byte", {24'h0, b}, 32'h0);
    chk("R1 irq", {31'h0, alarm_irq}, 32'h0);

    // R2/R3: load sweep, byte lanes, staged readback
    for (int i = 0; i < 24; i++) begin
      exp = (32'h9E3779B9 * i) ^ (32'(i) << 5);
      load_count(exp);
      read_count(v); chk("R3 load sweep", v, exp);
      bus_rd(4'h5, b); chk("R3 staged byte3", {24'h0, b}, {24'h0, exp[31:24]});
      set_ctrl(8'h80);
      for (int k = 0; k < i % 5; k++) pulse_tick();
      read_count(v); chk("R4 ticks advance", v, exp + 32'(i % 5));
      set_ctrl(8'h00);
    end

    // R2: rdata holds across idle cycles
    bus_rd(4'h6, b);
    repeat (3) @(negedge clk);
    chk("R2 rdata hold", {24'h0, bus_rdata}, {24'h0, b});

    // R4 + R9: stopped counter, undefined bits stored, no effect
    load_count(32'h12345678);
    set_ctrl(8'h7D);
    bus_rd(4'h0, b); chk("R9 ctrl readback", {24'h0, b}, 32'h7D);
    pulse_tick(); pulse_tick();
    read_count(v); chk("R4 stopped", v, 32'h12345678);
    bus_wr(4'h1, 8'hFE);
    bus_rd(4'h1, b); chk("R9 actl readback", {24'h0, b}, 32'hFE);

    // R4: load beats a tick in the same cycle
    set_ctrl(8'h80);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 4'h2; bus_wdata = 8'h11; tick = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tick = 0;
    read_count(v); chk("R4 load over tick", v, 32'h12345611);

    // R10: live bytes read only
    bus_wr(4'h6, 8'hAA); bus_wr(4'h9, 8'h55);
    read_count(v); chk("R10 live write ignored", v, 32'h12345611);

    // R2: unmapped offsets
    bus_wr(4'hE, 8'h5A);
    bus_rd(4'hE, b); chk("R2 unmapped", {24'h0, b}, 32'h0);

    // R5: wrap
    load_count(32'hFFFFFFFF);
    pulse_tick();
    read_count(v); chk("R5 wrap", v, 32'h0);

    // R6: torn read detected by byte 0 re-read
    load_count(32'h000001FF);
    bus_rd(4'h6, b0a);
    pulse_tick();
    bus_rd(4'h7, b);
    chk("R6 torn upper byte", {24'h0, b}, 32'h02);
    bus_rd(4'h6, b0b);
    chk("R6 carry seen", {31'h0, (b0b < b0a)}, 32'h1);
    read_count(v); chk("R6 reread", v, 32'h00000200);

    // R7: alarm fires on the matching tick only
    set_ctrl(8'h00);
    load_count(32'h00000103);
    bus_wr(4'hA, 8'h05); bus_wr(4'hB, 8'h01); bus_wr(4'hC, 8'h00); bus_wr(4'hD, 8'h00);
    bus_wr(4'h1, 8'h01);
    set_ctrl(8'h82);
    pulse_tick();
    chk("R7 before match", {31'h0, alarm_irq}, 32'h0);
    pulse_tick();
    chk("R7 match sets irq", {31'h0, alarm_irq}, 32'h1);
    set_ctrl(8'h80);
    chk("R7 sticky after disable", {31'h0, alarm_irq}, 32'h1);
    bus_rd(4'h1, b); chk("R8 status bit", {31'h0, b[0]}, 32'h1);
    bus_wr(4'h1, 8'h01);
    chk("R8 clear", {31'h0, alarm_irq}, 32'h0);
    bus_rd(4'h1, b); chk("R8 status cleared", {31'h0, b[0]}, 32'h0);

    // R7: load equal to alarm does not set
    set_ctrl(8'h02);
    load_count(32'h00000105);
    chk("R7 load no set", {31'h0, alarm_irq}, 32'h0);

    // R8: set wins over clear in the same cycle
    load_count(32'h00000104);
    set_ctrl(8'h82);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 4'h1; bus_wdata = 8'h01; tick = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tick = 0;
    chk("R8 set beats clear", {31'h0, alarm_irq}, 32'h1);
    bus_wr(4'h1, 8'h01);
    chk("R8 final clear", {31'h0, alarm_irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule